// File: doc/BRIEF.md
# Multi-Mode PWM Generator

This block drives one pulse-width-modulated output pin from a single clock. Time is counted in clock ticks. A small set of write strobes picks one of four waveform modes and loads the numbers each mode uses. Off mode holds the pin low. Standard mode runs a fixed 256-tick frame with an 8-bit high time. Fast mode spreads the same 8-bit density over the frame as isolated single-tick pulses. Variable mode alternates a programmable low phase and a programmable high phase, each 13 bits wide.

Duty and period writes land in pending registers. The running waveform picks them up only at its own boundary: the end of a 256-tick frame, or the end of a high phase in variable mode. This way no frame is ever cut short. Every mode write restarts the waveform from a clean state. A plain status pin reports when the block is off.

All inputs are plain control strobes that are accepted in the cycle they are high, so there is no back-pressure. The output is registered. Its value for waveform tick j appears j+1 rising edges after the edge that captures the mode write.

Top module: `multimode_pwm`

## Requirements
- R1: A synchronous active-high reset selects off mode and clears the duty value and both phase lengths to zero. While reset is applied and after it, the output is low and the idle flag is high. After reset, standard mode with no duty write stays low, and variable mode with no period write toggles every tick.
- R2: The mode code is 2 bits: 0 selects off, 1 selects standard, 2 selects fast, 3 selects variable. The idle flag is high exactly when the current mode is off.
- R3: In off mode the output stays low.
- R4: In standard mode, a duty value N from 0 to 255 makes the output high for ticks 0..N-1 of each 256-tick frame and low for the rest of the frame.
- R5: In fast mode, with duty N from 1 to 254, the output at frame tick t is high exactly when floor((t+1)·N/256) exceeds floor(t·N/256). This gives N isolated one-tick high pulses per frame below half duty, and isolated one-tick low pulses above half duty.
- R6: In fast mode, duty 0 gives a constant low output and duty 255 gives a constant high output.
- R7: In variable mode, each period is a low phase of lo+1 ticks followed by a high phase of hi+1 ticks, with lo and hi from 0 to 8191.
- R8: A duty write takes effect at the start of the next 256-tick frame. A period write takes effect after the current high phase ends. Until then the old values stay in force.
- R9: Duty writes do not change the output in variable mode. Period writes do not change the output in standard or fast mode.
- R10: Any mode write, including one that repeats the current mode, restarts the frame, the accumulator and the phase. It adopts the pending values. The output is low in the first cycle after the write, and tick 0 of the new waveform follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode code (0 off, 1 standard, 2 fast, 3 variable) |
| duty_we | input | 1 | Duty write strobe |
| duty_wdata | input | 8 | Duty value |
| period_we | input | 1 | Period write strobe, loads both phase lengths |
| lo_wdata | input | 13 | Low phase length minus one |
| hi_wdata | input | 13 | High phase length minus one |
| pwm_out | output | 1 | PWM output pin |
| idle | output | 1 | High while the mode is off |

## Verification
Output tick j of a new waveform is due at the (j+1)-th rising edge after the edge that captures the mode write. The cycle right after that edge is always low. The bench computes this whole expected stream from the requirements one cycle after the write, queues it, and has a monitor compare one queued value per falling edge, so each comparison lands mid-cycle, half a period after the edge that set the value. Mid-run duty and period writes are captured on the first edge after the stream starts. The expected stream switches to the new values exactly at the following frame or period boundary, so late adoption and early adoption both show up as mismatches.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_STD  = 2'd1,
    MODE_FAST = 2'd2,
    MODE_VAR  = 2'd3
  } pwm_mode_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int PER_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [1:0]        mode_wdata,
  input  logic              duty_we,
  input  logic [DUTY_W-1:0] duty_wdata,
  input  logic              period_we,
  input  logic [PER_W-1:0]  lo_wdata,
  input  logic [PER_W-1:0]  hi_wdata,
  output pwm_mode_e         mode_q,
  output logic [DUTY_W-1:0] duty_pend,
  output logic [PER_W-1:0]  lo_pend,
  output logic [PER_W-1:0]  hi_pend,
  output logic              restart
);
  // a mode write restarts the waveform in the same edge that loads the mode
  assign restart = mode_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_OFF;
      duty_pend <= '0;
      lo_pend   <= '0;
      hi_pend   <= '0;
    end else begin
      if (mode_we)   mode_q    <= pwm_mode_e'(mode_wdata);
      if (duty_we)   duty_pend <= duty_wdata;
      if (period_we) begin
        lo_pend <= lo_wdata;
        hi_pend <= hi_wdata;
      end
    end
  end

  // R1
  cfg_reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mode_q == MODE_OFF && duty_pend == '0 && lo_pend == '0 && hi_pend == '0));

  // R8
  cfg_duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !duty_we |=> $stable(duty_pend));
endmodule

// File: rtl/pwm_frame_core.sv
module pwm_frame_core #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              en,
  input  logic              fast_sel,
  input  logic [DUTY_W-1:0] duty_pend,
  output logic              level
);
  localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] cnt;
  logic [DUTY_W-1:0] acc;
  logic [DUTY_W-1:0] duty_act;
  logic [DUTY_W:0]   acc_sum;
  logic              frame_end;

  assign acc_sum   = {1'b0, acc} + {1'b0, duty_act};
  assign frame_end = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      acc      <= '0;
      duty_act <= '0;
    end else if (restart) begin
      cnt      <= '0;
      acc      <= '0;
      duty_act <= duty_pend;
    end else if (en) begin
      cnt <= cnt + 1'b1;
      acc <= acc_sum[DUTY_W-1:0];
      if (frame_end) duty_act <= duty_pend;
    end
  end

  always_comb begin
    if (fast_sel) begin
      level = (duty_act == CNT_MAX) ? 1'b1 : acc_sum[DUTY_W];
    end else begin
      level = (cnt < duty_act);
    end
  end

  // R4
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !restart && frame_end) |=> (cnt == '0));

  // R8
  duty_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !(en && frame_end)) |=> $stable(duty_act));

  // R5
  fast_acc_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en && fast_sel && !restart && frame_end) |=> (acc == '0));

  // R6
  fast_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_sel && duty_act == '0) |-> !level);
endmodule

// File: rtl/pwm_phase_core.sv
module pwm_phase_core #(
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             en,
  input  logic [PER_W-1:0] lo_pend,
  input  logic [PER_W-1:0] hi_pend,
  output logic             level
);
  logic [PER_W-1:0] pc;
  logic [PER_W-1:0] lo_act;
  logic [PER_W-1:0] hi_act;
  logic [PER_W-1:0] limit;
  logic             phase_hi;
  logic             phase_end;

  assign limit     = phase_hi ? hi_act : lo_act;
  assign phase_end = (pc == limit);
  assign level     = phase_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      phase_hi <= 1'b0;
      lo_act   <= '0;
      hi_act   <= '0;
    end else if (restart) begin
      pc       <= '0;
      phase_hi <= 1'b0;
      lo_act   <= lo_pend;
      hi_act   <= hi_pend;
    end else if (en) begin
      if (phase_end) begin
        pc       <= '0;
        phase_hi <= !phase_hi;
        if (phase_hi) begin
          lo_act <= lo_pend;
          hi_act <= hi_pend;
        end
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  // R7
  phase_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !restart) |-> (pc <= limit));

  // R8
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !(en && phase_hi && phase_end)) |=> ($stable(lo_act) && $stable(hi_act)));
endmodule

// File: rtl/multimode_pwm.sv
module multimode_pwm
  import pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int PER_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [1:0]        mode_wdata,
  input  logic              duty_we,
  input  logic [DUTY_W-1:0] duty_wdata,
  input  logic              period_we,
  input  logic [PER_W-1:0]  lo_wdata,
  input  logic [PER_W-1:0]  hi_wdata,
  output logic              pwm_out,
  output logic              idle
);
  pwm_mode_e         mode_q;
  logic [DUTY_W-1:0] duty_pend;
  logic [PER_W-1:0]  lo_pend;
  logic [PER_W-1:0]  hi_pend;
  logic              restart;
  logic              frame_en;
  logic              phase_en;
  logic              frame_level;
  logic              phase_level;
  logic              out_q;

  pwm_cfg_regs #(.DUTY_W(DUTY_W), .PER_W(PER_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .duty_we    (duty_we),
    .duty_wdata (duty_wdata),
    .period_we  (period_we),
    .lo_wdata   (lo_wdata),
    .hi_wdata   (hi_wdata),
    .mode_q     (mode_q),
    .duty_pend  (duty_pend),
    .lo_pend    (lo_pend),
    .hi_pend    (hi_pend),
    .restart    (restart)
  );

  assign frame_en = (mode_q == MODE_STD) || (mode_q == MODE_FAST);
  assign phase_en = (mode_q == MODE_VAR);

  pwm_frame_core #(.DUTY_W(DUTY_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .en        (frame_en),
    .fast_sel  (mode_q == MODE_FAST),
    .duty_pend (duty_pend),
    .level     (frame_level)
  );

  pwm_phase_core #(.PER_W(PER_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .en      (phase_en),
    .lo_pend (lo_pend),
    .hi_pend (hi_pend),
    .level   (phase_level)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      out_q <= 1'b0;
    end else begin
      unique case (mode_q)
        MODE_STD, MODE_FAST: out_q <= frame_level;
        MODE_VAR:            out_q <= phase_level;
        default:             out_q <= 1'b0;
      endcase
    end
  end

  assign pwm_out = out_q;
  assign idle    = (mode_q == MODE_OFF);

  // R3
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    idle |=> !pwm_out);

  // R10
  restart_low_chk: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> !pwm_out);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!pwm_out && idle));
endmodule

// File: tb/tb_multimode_pwm.sv
module tb_multimode_pwm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [1:0]  mode_wdata = '0;
  logic        duty_we = 1'b0;
  logic [7:0]  duty_wdata = '0;
  logic        period_we = 1'b0;
  logic [12:0] lo_wdata = '0;
  logic [12:0] hi_wdata = '0;
  logic        pwm_out;
  logic        idle;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  logic  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  multimode_pwm dut (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .duty_we    (duty_we),
    .duty_wdata (duty_wdata),
    .period_we  (period_we),
    .lo_wdata   (lo_wdata),
    .hi_wdata   (hi_wdata),
    .pwm_out    (pwm_out),
    .idle       (idle)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: one expected value per falling edge
  always @(negedge clk) begin
    logic  e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(pwm_out === e, t, int'(pwm_out), int'(e));
    end
  end

  // expected output k cycles after the edge capturing the mode write
  function automatic logic model(int mode, int n0, int n1, int lo0, int hi0,
                                 int lo1, int hi1, int k);
    int j, n, t, p0, p1, jj, lo;
    if (k == 0 || mode == 0) return 1'b0;
    j = k - 1;
    if (mode == 1 || mode == 2) begin
      n = (j < 256) ? n0 : n1;
      t = j % 256;
      if (mode == 1) return 1'(t < n);
      if (n == 255) return 1'b1;
      return 1'(((t + 1) * n) / 256 != (t * n) / 256);
    end
    p0 = lo0 + hi0 + 2;
    if (j < p0) begin
      jj = j;
      lo = lo0;
    end else begin
      p1 = lo1 + hi1 + 2;
      jj = (j - p0) % p1;
      lo = lo1;
    end
    return 1'(jj > lo);
  endfunction

  task automatic run_case(int mode, int n0, int n1, int lo0, int hi0, int lo1, int hi1,
                          int len, bit pre_duty, bit pre_per, bit mid_duty, bit mid_per,
                          string tag);
    @(negedge clk);
    duty_we    = pre_duty;
    duty_wdata = n0[7:0];
    period_we  = pre_per;
    lo_wdata   = lo0[12:0];
    hi_wdata   = hi0[12:0];
    @(negedge clk);
    duty_we    = 1'b0;
    period_we  = 1'b0;
    mode_we    = 1'b1;
    mode_wdata = mode[1:0];
    @(posedge clk);
    #1;
    mode_we = 1'b0;
    for (int k = 0; k < len; k++) begin
      exp_q.push_back(model(mode, n0, n1, lo0, hi0, lo1, hi1, k));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    // R2: idle flag follows the mode code
    check(idle === (mode == 0), "R2 idle flag", int'(idle), int'(mode == 0));
    duty_we    = mid_duty;
    duty_wdata = n1[7:0];
    period_we  = mid_per;
    lo_wdata   = lo1[12:0];
    hi_wdata   = hi1[12:0];
    @(negedge clk);
    duty_we   = 1'b0;
    period_we = 1'b0;
    while (exp_q.size() > 0) @(posedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(pwm_out === 1'b0, "R1 reset output", int'(pwm_out), 0);
    check(idle === 1'b1, "R1 reset idle", int'(idle), 1);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_out === 1'b0, "R1 after reset output", int'(pwm_out), 0);
    check(idle === 1'b1, "R1 after reset idle", int'(idle), 1);

    // R1 R4: cleared duty gives a low standard output
    run_case(1, 0, 0, 0, 0, 0, 0, 300, 0, 0, 0, 0, "R1 R4 std cleared duty");
    // R1 R7: cleared periods toggle every tick
    run_case(3, 0, 0, 0, 0, 0, 0, 64, 0, 0, 0, 0, "R1 R7 var cleared periods");
    // R4 R8 R9 R10: duty change at frame boundary, period write ignored
    run_case(1, 64, 200, 7, 9, 7, 9, 700, 1, 0, 1, 1, "R4 R8 R9 R10 std");
    run_case(1, 255, 255, 7, 9, 7, 9, 300, 1, 0, 0, 0, "R4 std max duty");
    // R5: pulse-density patterns
    run_case(2, 1,   1,   7, 9, 7, 9, 520, 1, 0, 0, 0, "R5 fast n1");
    run_case(2, 3,   3,   7, 9, 7, 9, 520, 1, 0, 0, 0, "R5 fast n3");
    run_case(2, 128, 128, 7, 9, 7, 9, 520, 1, 0, 0, 0, "R5 fast n128");
    run_case(2, 200, 200, 7, 9, 7, 9, 520, 1, 0, 0, 0, "R5 fast n200");
    run_case(2, 254, 254, 7, 9, 7, 9, 520, 1, 0, 0, 0, "R5 fast n254");
    // R6: constant extremes
    run_case(2, 0,   0,   7, 9, 7, 9, 300, 1, 0, 0, 0, "R6 fast n0");
    run_case(2, 255, 255, 7, 9, 7, 9, 300, 1, 0, 0, 0, "R6 fast n255");
    // R8 R9 R10: fast duty change at boundary, period write ignored
    run_case(2, 128, 1, 7, 9, 3, 3, 600, 1, 0, 1, 1, "R8 R9 R10 fast change");
    // R7 R8 R9: period change after high phase, duty write ignored
    run_case(3, 77, 10, 5, 2, 1, 3, 80, 0, 1, 1, 1, "R7 R8 R9 var change");
    run_case(3, 10, 10, 8191, 0, 8191, 0, 8300, 0, 1, 0, 0, "R7 var longest low");
    run_case(3, 10, 10, 0, 300, 0, 300, 700, 0, 1, 0, 0, "R7 var long high");
    // R10: restart mid-frame with the same mode
    run_case(1, 255, 255, 0, 300, 0, 300, 100, 1, 0, 0, 0, "R10 std first run");
    run_case(1, 255, 255, 0, 300, 0, 300, 300, 0, 0, 0, 0, "R10 std restart");
    // R3: off mode holds low
    run_case(0, 255, 255, 0, 300, 0, 300, 200, 0, 0, 0, 0, "R3 off low");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule